// File: doc/BRIEF.md
# I/Q Sample Input Controller

This block takes in-phase and quadrature samples into a receiver datapath. It accepts them either as two parallel words or as two single-bit serial lines, and it delivers each sample pair to a downstream stage as one registered word pair with a valid flag. The input coding is selected by a format control, either two's complement or offset binary. The output is always two's complement: for offset-binary input the sign bit is inverted, and two's-complement input passes through unchanged.

In parallel mode, a pair is captured on any clock edge where the active-low sample enable is low. In serial mode, a bit strobe in the clock domain acts as the serial clock. On a strobe, a high word-sync marks the slot just ahead of the first data bit. The following strobes shift one bit per lane, MSB first, until a full word has been taken. After that the shifter freezes. The next sync hands the frozen word to the output and re-arms the shifter for the strobe after it. If a sync arrives before the word is complete, the partial contents are handed over anyway and shifting restarts.

The output follows valid/ready. The input side runs at line rate and cannot be stalled, so back-pressure works as follows. While `out_valid` is high and `out_ready` is low, the word pair is held. If a new sample is captured during that stall, it replaces the held pair, and `out_valid` stays high.

Top module: `iq_input_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid` goes low after that edge, the serial shifters clear to zero, and the serial bit count clears to zero.
- R2: With `mode_serial`=0 and `par_en_n`=0 at an edge, `par_i`/`par_q` are format-converted and appear on `out_i`/`out_q`, with `out_valid` high, right after that edge.
- R3: With `mode_serial`=0 and `par_en_n`=1, no sample is captured. With `mode_serial`=1, `par_en_n` and the parallel buses have no effect.
- R4: In serial mode, after a strobe carrying sync, each of the next SAMPLE_W strobes shifts one bit into each lane, MSB first. The first bit after sync ends up at bit SAMPLE_W-1.
- R5: Once SAMPLE_W bits have been shifted, further strobes without sync leave the lane registers unchanged.
- R6: A strobe with `ser_sync`=1 hands the current lane contents, format-converted, to the output with `out_valid` high after that edge. Shifting restarts on the next strobe. No bit is taken on the sync strobe itself.
- R7: A sync that arrives after fewer than SAMPLE_W bits still hands over the partial contents, meaning the old word shifted left by the number of bits taken, and restarts shifting.
- R8: With `fmt_offset`=1, output bit SAMPLE_W-1 is the inverse of input bit SAMPLE_W-1, and all other bits are equal. With `fmt_offset`=0, the output equals the input.
- R9: While `out_valid`=1 and `out_ready`=0, the output pair is held. A new capture in that state replaces it, and `out_valid` stays high. `out_valid` drops after an edge where `out_ready`=1 and nothing is captured.
- R10: `ser_sync`, `ser_i` and `ser_q` have no effect on cycles where `ser_bit_en`=0, and no effect at all while `mode_serial`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_serial | input | 1 | 0 = parallel entry, 1 = serial entry |
| fmt_offset | input | 1 | 0 = two's complement input, 1 = offset binary input |
| par_en_n | input | 1 | Active-low sample enable for parallel mode |
| par_i | input | SAMPLE_W | Parallel in-phase word |
| par_q | input | SAMPLE_W | Parallel quadrature word |
| ser_bit_en | input | 1 | Serial bit strobe, one clock wide per serial clock |
| ser_sync | input | 1 | Word sync, sampled on strobe cycles |
| ser_i | input | 1 | Serial in-phase bit |
| ser_q | input | 1 | Serial quadrature bit |
| out_valid | output | 1 | Output word pair valid |
| out_ready | input | 1 | Downstream accepts the pair |
| out_i | output | SAMPLE_W | Two's-complement in-phase output |
| out_q | output | SAMPLE_W | Two's-complement quadrature output |

## Verification
The bench builds the block with the default SAMPLE_W of 10. This makes a full serial frame of ten strobes short enough to exercise many times, alongside frames cut off after a few bits and idle strobes after a frozen word. It also places the sign-bit inversion at bit 9, where patterns such as 10'h2A5 expose any swap of MSB and LSB order. Random segments switch between modes, formats and ready levels mid-frame, so stalls that overlap serial transfers and parallel captures are reached as well.

// File: rtl/iq_in_pkg.sv
package iq_in_pkg;
  typedef enum logic {
    ENTRY_PAR = 1'b0,
    ENTRY_SER = 1'b1
  } entry_mode_e;

  localparam int NUM_LANES = 2;
  localparam int LANE_I = 0;
  localparam int LANE_Q = 1;
endpackage

// File: rtl/iq_fmt_conv.sv
module iq_fmt_conv #(
  parameter int SAMPLE_W = 10
) (
  input  logic                fmt_offset,
  input  logic [SAMPLE_W-1:0] din,
  output logic [SAMPLE_W-1:0] dout
);
  // offset binary differs from two's complement only in the sign bit
  always_comb begin
    dout = din;
    dout[SAMPLE_W-1] = din[SAMPLE_W-1] ^ fmt_offset;
  end
endmodule

// File: rtl/iq_ser_frame.sv
module iq_ser_frame #(
  parameter int SAMPLE_W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic sync,
  output logic shift_en,
  output logic xfer
);
  localparam int CNT_W = $clog2(SAMPLE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(SAMPLE_W);

  logic [CNT_W-1:0] bits_left;

  assign xfer     = strobe && sync;
  assign shift_en = strobe && !sync && (bits_left != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bits_left <= '0;
    end else if (xfer) begin
      bits_left <= FULL;
    end else if (shift_en) begin
      bits_left <= bits_left - 1'b1;
    end
  end

  // R6: a sync strobe re-arms a full word of shifting
  a_r6_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && sync) |=> (bits_left == FULL));

  // R5: with no bits left, a plain strobe takes nothing
  a_r5_no_extra_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (bits_left == '0 && !sync) |-> !shift_en);
endmodule

// File: rtl/iq_ser_lane.sv
module iq_ser_lane #(
  parameter int SAMPLE_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_en,
  input  logic                bit_in,
  output logic [SAMPLE_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word <= '0;
    end else if (shift_en) begin
      word <= {word[SAMPLE_W-2:0], bit_in};
    end
  end

  // R4: MSB first, so each new bit enters at the bottom and older bits move up
  a_r4_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (word[0] == $past(bit_in)) &&
                 (word[SAMPLE_W-1:1] == $past(word[SAMPLE_W-2:0])));

  // R5: the lane is frozen whenever no shift is granted
  a_r5_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(word));
endmodule

// File: rtl/iq_input_ctrl.sv
module iq_input_ctrl
  import iq_in_pkg::*;
#(
  parameter int SAMPLE_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_serial,
  input  logic                fmt_offset,
  input  logic                par_en_n,
  input  logic [SAMPLE_W-1:0] par_i,
  input  logic [SAMPLE_W-1:0] par_q,
  input  logic                ser_bit_en,
  input  logic                ser_sync,
  input  logic                ser_i,
  input  logic                ser_q,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_i,
  output logic [SAMPLE_W-1:0] out_q
);
  entry_mode_e mode;
  logic ser_act, shift_en, ser_xfer, par_cap, capture;
  logic [NUM_LANES-1:0]               ser_bits;
  logic [NUM_LANES-1:0][SAMPLE_W-1:0] lane_word;
  logic [NUM_LANES-1:0][SAMPLE_W-1:0] par_word;
  logic [NUM_LANES-1:0][SAMPLE_W-1:0] raw_word;
  logic [NUM_LANES-1:0][SAMPLE_W-1:0] conv_word;

  assign mode     = entry_mode_e'(mode_serial);
  assign ser_act  = (mode == ENTRY_SER) && ser_bit_en;
  assign par_cap  = (mode == ENTRY_PAR) && !par_en_n;
  assign ser_bits = {ser_q, ser_i};
  assign par_word = {par_q, par_i};

  iq_ser_frame #(.SAMPLE_W(SAMPLE_W)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (ser_act),
    .sync     (ser_sync),
    .shift_en (shift_en),
    .xfer     (ser_xfer)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    iq_ser_lane #(.SAMPLE_W(SAMPLE_W)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_en),
      .bit_in   (ser_bits[g]),
      .word     (lane_word[g])
    );

    assign raw_word[g] = (mode == ENTRY_SER) ? lane_word[g] : par_word[g];

    iq_fmt_conv #(.SAMPLE_W(SAMPLE_W)) u_conv (
      .fmt_offset (fmt_offset),
      .din        (raw_word[g]),
      .dout       (conv_word[g])
    );
  end

  assign capture = par_cap || ser_xfer;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else if (capture) begin
      out_valid <= 1'b1;
      out_i     <= conv_word[LANE_I];
      out_q     <= conv_word[LANE_Q];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R2: parallel two's-complement capture shows the bus words next cycle
  a_r2_par_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_serial && !par_en_n && !fmt_offset) |=>
      out_valid && (out_i == $past(par_i)) && (out_q == $past(par_q)));

  // R9: a stalled pair is held until accepted or replaced
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !capture) |=>
      out_valid && $stable(out_i) && $stable(out_q));

  // R9: accepted with nothing new means valid drops
  a_r9_accept_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && !capture) |=> !out_valid);

  // R10: without a strobe in serial mode nothing is handed over
  a_r10_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_serial && !ser_bit_en && !out_valid) |=> !out_valid);
endmodule

// File: tb/iq_input_ctrl_bench.sv
module iq_input_ctrl_bench;
  localparam int W = 10;

  logic clk = 1'b0;
  logic rst_n, mode_serial, fmt_offset, par_en_n, ser_bit_en, ser_sync, ser_i, ser_q, out_ready;
  logic [W-1:0] par_i, par_q, out_i, out_q;
  logic out_valid;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  // bench model state
  logic [W-1:0] m_sh_i, m_sh_q, m_oi, m_oq;
  int m_cnt;
  logic m_v;

  always #4 clk = ~clk;

  iq_input_ctrl #(.SAMPLE_W(W)) u_iq_input_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_serial(mode_serial), .fmt_offset(fmt_offset),
    .par_en_n(par_en_n), .par_i(par_i), .par_q(par_q), .ser_bit_en(ser_bit_en),
    .ser_sync(ser_sync), .ser_i(ser_i), .ser_q(ser_q), .out_valid(out_valid),
    .out_ready(out_ready), .out_i(out_i), .out_q(out_q)
  );

  function automatic logic [W-1:0] to_twos(input logic [W-1:0] v, input logic off);
    return off ? {~v[W-1], v[W-2:0]} : v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock edge: model advances from the inputs held across the edge, then outputs compared
  task automatic tick(input string req);
    logic cap_par, act, cap_ser;
    @(posedge clk);
    #1;
    if (!rst_n) begin
      m_sh_i = '0; m_sh_q = '0; m_cnt = 0; m_v = 1'b0; m_oi = '0; m_oq = '0;
    end else begin
      cap_par = !mode_serial && !par_en_n;
      act     = mode_serial && ser_bit_en;
      cap_ser = act && ser_sync;
      if (cap_par) begin
        m_v = 1'b1; m_oi = to_twos(par_i, fmt_offset); m_oq = to_twos(par_q, fmt_offset);
      end else if (cap_ser) begin
        m_v = 1'b1; m_oi = to_twos(m_sh_i, fmt_offset); m_oq = to_twos(m_sh_q, fmt_offset);
      end else if (out_ready) begin
        m_v = 1'b0;
      end
      if (cap_ser) m_cnt = W;
      else if (act && m_cnt != 0) begin
        m_sh_i = {m_sh_i[W-2:0], ser_i};
        m_sh_q = {m_sh_q[W-2:0], ser_q};
        m_cnt--;
      end
    end
    check({req, " valid"}, 32'(out_valid), 32'(m_v));
    if (m_v) begin
      check({req, " out_i"}, 32'(out_i), 32'(m_oi));
      check({req, " out_q"}, 32'(out_q), 32'(m_oq));
    end
  endtask

  task automatic idle_inputs();
    par_en_n = 1'b1; ser_bit_en = 1'b0; ser_sync = 1'b0; ser_i = 1'b0; ser_q = 1'b0;
  endtask

  task automatic strobe(input logic sy, input logic bi, input logic bq, input string req);
    ser_bit_en = 1'b1; ser_sync = sy; ser_i = bi; ser_q = bq;
    tick(req);
    idle_inputs();
    tick(req);
  endtask

  task automatic ser_frame(input logic [W-1:0] wi, input logic [W-1:0] wq, input int nbits, input string req);
    strobe(1'b1, 1'b0, 1'b0, req);
    for (int b = 0; b < nbits; b++) strobe(1'b0, wi[W-1-b], wq[W-1-b], req);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; mode_serial = 1'b0; fmt_offset = 1'b0; out_ready = 1'b1;
    par_i = '0; par_q = '0;
    idle_inputs();
    tick("R1"); tick("R1");
    check("R1 reset valid", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    tick("R1");

    // R2 parallel capture, both formats
    par_i = 10'h1F3; par_q = 10'h20C; par_en_n = 1'b0;
    tick("R2");
    check("R2 par out_i", 32'(out_i), 32'h1F3);
    fmt_offset = 1'b1; par_i = 10'h3FF; par_q = 10'h000;
    tick("R8");
    check("R8 offset out_i", 32'(out_i), 32'h1FF);
    check("R8 offset out_q", 32'(out_q), 32'h200);
    fmt_offset = 1'b0; par_en_n = 1'b1;
    tick("R3"); tick("R3");
    check("R3 enable high no capture", 32'(out_valid), 32'd0);

    // R10 serial lines ignored in parallel mode
    ser_bit_en = 1'b1; ser_sync = 1'b1; tick("R10"); idle_inputs(); tick("R10");
    check("R10 par mode sync ignored", 32'(out_valid), 32'd0);

    // serial path
    mode_serial = 1'b1;
    // R1: first sync after reset hands over the cleared shifter
    strobe(1'b1, 1'b0, 1'b0, "R1");
    ser_frame(10'h2A5, 10'h13C, W, "R4");
    strobe(1'b0, 1'b1, 1'b1, "R5"); strobe(1'b0, 1'b1, 1'b1, "R5");
    // R6 sync transfers the frozen word
    ser_bit_en = 1'b1; ser_sync = 1'b1; tick("R6");
    check("R6 serial out_i", 32'(out_i), 32'h2A5);
    check("R6 serial out_q", 32'(out_q), 32'h13C);
    idle_inputs(); tick("R6");
    // R3 parallel enable ignored in serial mode
    par_en_n = 1'b0; par_i = 10'h111; tick("R3"); par_en_n = 1'b1; tick("R3");
    check("R3 serial mode ignores par", 32'(out_valid), 32'd0);
    // R10 sync without strobe ignored
    ser_sync = 1'b1; tick("R10"); ser_sync = 1'b0; tick("R10");
    check("R10 sync w/o strobe", 32'(out_valid), 32'd0);
    // R7 short frame: 4 bits 1,0,1,1 after frame restarted
    for (int b = 0; b < 4; b++) strobe(1'b0, (b != 1), 1'b0, "R7");
    ser_bit_en = 1'b1; ser_sync = 1'b1; tick("R7");
    check("R7 short frame out_i", 32'(out_i), 32'h25B);
    check("R7 short frame out_q", 32'(out_q), 32'h3C0);
    idle_inputs(); tick("R7");

    // R9 stall, replace, then accept
    out_ready = 1'b0; mode_serial = 1'b0;
    par_i = 10'h055; par_q = 10'h0AA; par_en_n = 1'b0; tick("R9");
    par_en_n = 1'b1; tick("R9"); tick("R9");
    check("R9 held", 32'(out_i), 32'h055);
    par_i = 10'h066; par_en_n = 1'b0; tick("R9"); par_en_n = 1'b1; tick("R9");
    check("R9 replaced", 32'(out_i), 32'h066);
    out_ready = 1'b1; tick("R9");
    check("R9 drop after accept", 32'(out_valid), 32'd0);

    // constrained random mix, model compares every cycle
    for (int n = 0; n < 3000; n++) begin
      logic last_sync;
      if (n % 200 == 0) begin
        mode_serial = $urandom_range(0, 1);
        fmt_offset  = $urandom_range(0, 1);
      end
      out_ready = ($urandom_range(0, 3) != 0);
      par_i = W'($urandom); par_q = W'($urandom);
      par_en_n = ($urandom_range(0, 2) != 0);
      ser_bit_en = ($urandom_range(0, 1) == 1);
      last_sync = ser_sync;
      ser_sync = ser_bit_en && !last_sync && ($urandom_range(0, 11) == 0);
      ser_i = $urandom_range(0, 1); ser_q = $urandom_range(0, 1);
      tick(mode_serial ? "R6 random serial" : "R2 random parallel");
    end

    idle_inputs();
    rst_n = 1'b0; tick("R1");
    check("R1 reset mid-run", 32'(out_valid), 32'd0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule